// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Decay Modes

This block drives the four gate enables of one full bridge: a high-side and a low-side switch on leg A and on leg B. Each clock it combines four synchronous inputs: bridge enable, the on-request from the current chopper, the direction bit from the phase sequencer and the decay-mode select. From these it forms the gate pattern the bridge should reach. It then moves the outputs towards that pattern without ever shorting a leg.

A switch that turns on always waits a programmable dead interval. During that interval the gates are held at the overlap of the old and new patterns, so that switches wanted in both stay on and all others are off. Switches that only turn off drop at the next clock edge. In the off phase, fast decay turns the bridge fully off and then closes only the low-side switch that parallels the freewheeling diode. This quasi-synchronous rectification keeps the winding current from reversing. Slow decay opens only the conducting low side and then closes the second high side, so the current circulates through the upper half of the bridge.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, all four gate enables are low.
- R2: When bridge enable is low, all four gates are low from the next clock edge. They stay low whatever the other inputs do, with no dead interval before the turn-off.
- R3: With enable high and the on-request high, direction high settles to high-side A plus low-side B. Direction low settles to high-side B plus low-side A.
- R4: The high-side and low-side gates of the same leg are never both on in any cycle.
- R5: Whenever the target pattern would turn on a switch that is currently off, the gates hold the overlap of the current and target patterns for DEAD_CYCLES cycles. The target appears at the clock edge after that.
- R6: Fast decay (decay select low, on-request low) first turns all gates off for the dead interval. It then turns on only low-side A when direction is high, or only low-side B when direction is low.
- R7: Slow decay (decay select high, on-request low) turns off only the conducting low-side switch and keeps its high side on for the dead interval. It then has both high-side switches on, independent of direction.
- R8: When the on-request rises again after an off phase, the on-state switches return only after the dead interval. A high side that stayed on during slow decay remains on throughout.
- R9: A direction change while the bridge is on passes through an all-off dead interval before the opposite diagonal turns on.
- R10: A change of inputs during a dead interval restarts the interval from the new overlap. The new target appears DEAD_CYCLES+1 edges after the change, not at the end of the earlier interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bridgeEn | input | 1 | Bridge enable; low forces all gates off |
| onReq | input | 1 | Chopper on-request; high selects the on phase, low the off phase |
| dirFwd | input | 1 | Current direction; high selects high-side A with low-side B |
| slowDecay | input | 1 | Decay select; high selects slow decay, low fast decay |
| gateHiA | output | 1 | Leg A high-side gate enable |
| gateLoA | output | 1 | Leg A low-side gate enable |
| gateHiB | output | 1 | Leg B high-side gate enable |
| gateLoB | output | 1 | Leg B low-side gate enable |

## Verification
The assertions assume that all four control inputs are synchronous to the clock and settled before each rising edge. They also assume that reset is held for at least one edge before the first request, so the dead-interval monitor starts from an all-off bridge. The stimulus changes inputs only on the falling clock edge. It holds each setting for random lengths, some shorter than the dead interval, so that retargeting mid-interval and disabling inside an interval both occur without breaking those assumptions.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Bit positions of the gate pattern vector
  localparam int HI_A = 0;
  localparam int LO_A = 1;
  localparam int HI_B = 2;
  localparam int LO_B = 3;
  localparam int NUM_GATES = 4;

  typedef logic [NUM_GATES-1:0] gate_pat_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic direct;   // take target at once (only switches turning off)
    logic cut;      // hold overlap, load target, restart dead counter
    logic commit;   // dead interval over, apply target
    logic tick;     // count the dead interval down
  } hbg_strobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic matchApplied;
    logic subsetApplied;
    logic matchGoal;
    logic cntZero;
  } hbg_status_t;

  typedef enum logic [0:0] {ST_SETTLED, ST_DEAD} hbg_state_t;

endpackage

// File: rtl/hbg_decode.sv
module hbg_decode
  import hbg_pkg::*;
(
  input  logic      bridgeEn,
  input  logic      onReq,
  input  logic      dirFwd,
  input  logic      slowDecay,
  output gate_pat_t desired
);

  gate_pat_t onPat;
  gate_pat_t fastPat;
  gate_pat_t slowPat;

  always_comb begin
    onPat   = '0;
    fastPat = '0;
    slowPat = '0;
    // diagonal pair chosen by direction
    if (dirFwd) begin
      onPat[HI_A] = 1'b1;
      onPat[LO_B] = 1'b1;
      fastPat[LO_A] = 1'b1;   // low side parallel to the conducting diode
    end else begin
      onPat[HI_B] = 1'b1;
      onPat[LO_A] = 1'b1;
      fastPat[LO_B] = 1'b1;
    end
    // recirculation through the upper half bridge
    slowPat[HI_A] = 1'b1;
    slowPat[HI_B] = 1'b1;
  end

  always_comb begin
    if (!bridgeEn)      desired = '0;
    else if (onReq)     desired = onPat;
    else if (slowDecay) desired = slowPat;
    else                desired = fastPat;
  end

endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  gate_pat_t   desired,
  input  hbg_strobe_t strobe,
  output hbg_status_t status,
  output gate_pat_t   applied
);

  localparam int CNT_W = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYCLES - 1);

  gate_pat_t        goal;
  logic [CNT_W-1:0] deadCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      applied <= '0;
      goal    <= '0;
      deadCnt <= '0;
    end else begin
      if (strobe.direct) begin
        applied <= desired;
      end else if (strobe.cut) begin
        applied <= applied & desired;
        goal    <= desired;
        deadCnt <= CNT_LOAD;
      end else if (strobe.commit) begin
        applied <= goal;
      end else if (strobe.tick) begin
        deadCnt <= deadCnt - 1'b1;
      end
    end
  end

  always_comb begin
    status.matchApplied  = (desired == applied);
    status.subsetApplied = ((desired & ~applied) == '0);
    status.matchGoal     = (desired == goal);
    status.cntZero       = (deadCnt == '0);
  end

endmodule

// File: rtl/hbg_control.sv
module hbg_control
  import hbg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  hbg_status_t status,
  output hbg_strobe_t strobe
);

  hbg_state_t state;
  hbg_state_t stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SETTLED;
    else       state <= stateNext;
  end

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_SETTLED: begin
        if (!status.matchApplied) begin
          if (status.subsetApplied) begin
            strobe.direct = 1'b1;
          end else begin
            strobe.cut = 1'b1;
            stateNext  = ST_DEAD;
          end
        end
      end
      ST_DEAD: begin
        if (!status.matchGoal) begin
          if (status.subsetApplied) begin
            strobe.direct = 1'b1;
            stateNext     = ST_SETTLED;
          end else begin
            strobe.cut = 1'b1;
          end
        end else if (status.cntZero) begin
          strobe.commit = 1'b1;
          stateNext     = ST_SETTLED;
        end else begin
          strobe.tick = 1'b1;
        end
      end
      default: stateNext = ST_SETTLED;
    endcase
  end

endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 200
) (
  input  logic clk,
  input  logic rstN,
  input  logic bridgeEn,
  input  logic onReq,
  input  logic dirFwd,
  input  logic slowDecay,
  output logic gateHiA,
  output logic gateLoA,
  output logic gateHiB,
  output logic gateLoB
);

  gate_pat_t   desired;
  gate_pat_t   applied;
  hbg_strobe_t strobe;
  hbg_status_t status;

  hbg_decode u_decode (
    .bridgeEn  (bridgeEn),
    .onReq     (onReq),
    .dirFwd    (dirFwd),
    .slowDecay (slowDecay),
    .desired   (desired)
  );

  hbg_datapath #(.DEAD_CYCLES(DEAD_CYCLES)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .desired (desired),
    .strobe  (strobe),
    .status  (status),
    .applied (applied)
  );

  hbg_control u_control (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

  assign gateHiA = applied[HI_A];
  assign gateLoA = applied[LO_A];
  assign gateHiB = applied[HI_B];
  assign gateLoB = applied[LO_B];

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int DEAD_CYCLES = 200
) (
  input logic clk,
  input logic rstN,
  input logic bridgeEn,
  input logic gateHiA,
  input logic gateLoA,
  input logic gateHiB,
  input logic gateLoB
);

  localparam int QW = $clog2(DEAD_CYCLES + 1);
  localparam logic [QW-1:0] Q_MAX  = QW'(DEAD_CYCLES);
  localparam logic [QW-1:0] Q_NEED = QW'(DEAD_CYCLES - 1);

  logic [3:0]    gatesNow;
  logic [3:0]    gatesPrev;
  logic [QW-1:0] quiet;
  logic          anyFell;
  logic          anyRose;

  assign gatesNow = {gateLoB, gateHiB, gateLoA, gateHiA};
  assign anyFell  = |(gatesPrev & ~gatesNow);
  assign anyRose  = |(gatesNow & ~gatesPrev);

  // cycles since the last gate turned off, saturating
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gatesPrev <= '0;
      quiet     <= '0;
    end else begin
      gatesPrev <= gatesNow;
      if (anyFell)            quiet <= '0;
      else if (quiet < Q_MAX) quiet <= quiet + 1'b1;
    end
  end

  AST_LEG_A_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHiA && gateLoA)); // R4
  AST_LEG_B_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHiB && gateLoB)); // R4
  AST_AT_MOST_TWO_ON: assert property (@(posedge clk) disable iff (!rstN)
    $countones(gatesNow) <= 2); // R4
  AST_DISABLE_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !bridgeEn |=> (gatesNow == 4'b0000)); // R2
  AST_DEAD_BEFORE_ON: assert property (@(posedge clk) disable iff (!rstN)
    anyRose |-> (quiet >= Q_NEED)); // R5

endmodule

bind hbridge_gate_seq hbg_checker #(.DEAD_CYCLES(DEAD_CYCLES)) u_hbg_checker (
  .clk      (clk),
  .rstN     (rstN),
  .bridgeEn (bridgeEn),
  .gateHiA  (gateHiA),
  .gateLoA  (gateLoA),
  .gateHiB  (gateHiB),
  .gateLoB  (gateLoB)
);

// File: tb/test_hbridge_gate_seq.sv
`timescale 1ns/1ps
module test_hbridge_gate_seq;

  localparam int DEAD = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, bridgeEn, onReq, dirFwd, slowDecay;
  logic gateHiA, gateLoA, gateHiB, gateLoB;

  hbridge_gate_seq #(.DEAD_CYCLES(DEAD)) i_hbridge_gate_seq (
    .clk(clk), .rstN(rstN), .bridgeEn(bridgeEn), .onReq(onReq),
    .dirFwd(dirFwd), .slowDecay(slowDecay),
    .gateHiA(gateHiA), .gateLoA(gateLoA), .gateHiB(gateHiB), .gateLoB(gateLoB)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit modelOn = 1'b0;

  // pattern bits: [0] hi A, [1] lo A, [2] hi B, [3] lo B
  wire [3:0] dutPat = {gateLoB, gateHiB, gateLoA, gateHiA};

  function automatic logic [3:0] wantPat(logic en, logic on, logic dir, logic slow);
    if (!en)      return 4'b0000;
    if (on)       return dir ? 4'b1001 : 4'b0110;
    if (slow)     return 4'b0101;
    return dir ? 4'b0010 : 4'b1000;
  endfunction

  // requirement-level reference for the gate sequence
  logic [3:0] mApp, mGoal;
  int mCnt;
  bit mDead;

  always @(posedge clk) begin
    logic [3:0] des;
    des = wantPat(bridgeEn, onReq, dirFwd, slowDecay);
    if (!rstN) begin
      mApp <= '0; mGoal <= '0; mCnt <= 0; mDead <= 1'b0;
    end else if ((!mDead && des != mApp) || (mDead && des != mGoal)) begin
      if ((des & ~mApp) == 4'b0000) begin
        mApp <= des; mDead <= 1'b0;
      end else begin
        mApp <= mApp & des; mGoal <= des; mCnt <= DEAD - 1; mDead <= 1'b1;
      end
    end else if (mDead) begin
      if (mCnt == 0) begin
        mApp <= mGoal; mDead <= 1'b0;
      end else begin
        mCnt <= mCnt - 1;
      end
    end
  end

  function automatic string modelTag();
    if (mDead)          return "R5";
    if (!bridgeEn)      return "R2";
    if (onReq)          return "R3";
    if (slowDecay)      return "R7";
    return "R6";
  endfunction

  task automatic check(logic [3:0] exp, string tag);
    checks++;
    if (dutPat !== exp) begin
      errors++;
      $display("FAIL %s: gates actual %b expected %b at %0t", tag, dutPat, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (modelOn && rstN) check(mApp, modelTag());
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setIn(logic en, logic on, logic dir, logic slow);
    bridgeEn = en; onReq = on; dirFwd = dir; slowDecay = slow;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rstN = 1'b0;
    setIn(1'b1, 1'b1, 1'b1, 1'b0);
    step(3);
    check(4'b0000, "R1");
    rstN = 1'b1;
    setIn(1'b0, 1'b0, 1'b0, 1'b0);
    step(2);
    check(4'b0000, "R1");
    modelOn = 1'b1;

    // on, direction high
    setIn(1'b1, 1'b1, 1'b1, 1'b0);
    step(1);        check(4'b0000, "R5");
    step(DEAD - 1); check(4'b0000, "R5");
    step(1);        check(4'b1001, "R3");

    // fast decay off phase
    setIn(1'b1, 1'b0, 1'b1, 1'b0);
    step(1);        check(4'b0000, "R6");
    step(DEAD);     check(4'b0010, "R6");

    // back on
    setIn(1'b1, 1'b1, 1'b1, 1'b0);
    step(1);        check(4'b0000, "R8");
    step(DEAD);     check(4'b1001, "R8");

    // slow decay off phase
    setIn(1'b1, 1'b0, 1'b1, 1'b1);
    step(1);        check(4'b0001, "R7");
    step(DEAD);     check(4'b0101, "R7");

    // back on from slow decay keeps hi A
    setIn(1'b1, 1'b1, 1'b1, 1'b1);
    step(1);        check(4'b0001, "R8");
    step(DEAD);     check(4'b1001, "R8");

    // direction change while on
    setIn(1'b1, 1'b1, 1'b0, 1'b1);
    step(1);        check(4'b0000, "R9");
    step(DEAD);     check(4'b0110, "R9");

    // fast decay with direction low
    setIn(1'b1, 1'b0, 1'b0, 1'b0);
    step(1);        check(4'b0000, "R6");
    step(DEAD);     check(4'b1000, "R6");

    // retarget during the dead interval
    setIn(1'b1, 1'b1, 1'b0, 1'b0);
    step(2);
    setIn(1'b1, 1'b1, 1'b1, 1'b0);
    step(DEAD);     check(4'b0000, "R10");
    step(1);        check(4'b1001, "R10");

    // disable: immediate turn-off, other inputs ignored
    setIn(1'b0, 1'b1, 1'b1, 1'b0);
    step(1);        check(4'b0000, "R2");
    for (int i = 0; i < 6; i++) begin
      setIn(1'b0, 1'(i), 1'(i >> 1), 1'(i >> 2));
      step(1);      check(4'b0000, "R2");
    end

    // disable inside a dead interval
    setIn(1'b1, 1'b1, 1'b0, 1'b0);
    step(3);
    setIn(1'b0, 1'b1, 1'b0, 1'b0);
    step(1);        check(4'b0000, "R2");
    step(DEAD + 1); check(4'b0000, "R2");

    // constrained random phase, checked every cycle against the reference
    for (int seg = 0; seg < 3000; seg++) begin
      setIn(1'(($urandom % 8) != 0), 1'($urandom), 1'($urandom), 1'($urandom));
      step(1 + int'($urandom % (3 * DEAD)));
    end

    step(2);
    finishRun();
  end

endmodule